// File: doc/BRIEF.md
# Refresh-Driven Watchdog Reset Timer

This block guards against software that has stopped running its normal path. A free-running divider produces one step pulse every `PRESCALE` input clocks. Each step lowers a 7-bit counter by one. The enable flag and the counter sit together in one 8-bit register: the flag is bit 7 and the counter is bits 6:0. Software refreshes the watchdog by writing that register, which reloads the counter and restarts the divider.

Once the flag is set, a reset pulse starts in either of two cases: the counter falls from 40h to 3Fh, or software writes a value whose bit 6 is clear. The pulse holds the active-low reset output low for `PULSE_LEN` clocks. A refresh value therefore lies between C0h and FFh. Bits 5:0 of that value choose one of 64 timeout lengths, each a multiple of `PRESCALE` clocks.

Top module: `wdg_timer`

## Requirements
- R1: After the synchronous reset `rst`, `rd_data` reads 7Fh (flag clear, counter 7Fh), `wdg_rst_n` is high and the divider is cleared. A reset during a pulse releases `wdg_rst_n` on the next clock.
- R2: `rd_data` always shows the flag in bit 7 and the live counter in bits 6:0.
- R3: A write loads `wr_data[6:0]` into the counter and clears the divider. The first step after a write comes exactly `PRESCALE` clocks after the write edge. A write wins over a step that falls on the same edge.
- R4: Without writes, the counter drops by one every `PRESCALE` clocks and wraps from 00h to 7Fh.
- R5: A write with `wr_data[7]`=1 sets the flag. A write with bit 7 clear leaves the flag unchanged, so only `rst` clears it.
- R6: With the flag set, the step that takes the counter from 40h to 3Fh starts a reset pulse at that same edge.
- R7: A write with `wr_data[6]`=0 starts a reset pulse at the write edge if the flag is set, or if that same write sets the flag.
- R8: A pulse holds `wdg_rst_n` low for exactly `PULSE_LEN` clocks (default 4) and then releases it.
- R9: With the flag clear, `wdg_rst_n` stays high. This holds across the 40h-to-3Fh step and for writes with bit 6 clear.
- R10: Refresh writes with bit 6 set, issued more often than the timeout, keep `wdg_rst_n` high indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data: bit 7 enable, bits 6:0 counter |
| rd_data | output | 8 | Read data: flag and live counter |
| wdg_rst_n | output | 1 | Active-low reset pulse |

## Verification
The bench issues a refresh on exactly the edge where the divider would have stepped. A design that lets the step win, or that does not restart the divider, fires one period early. It checks the exact cycle of the 40h-to-3Fh firing and of the bit-6-clear write firing, so a design that waits until the counter reaches zero, or that ignores bad writes, misses the expected cycle. It also tries to clear the flag with a bit-7-clear write and crosses 40h with the flag clear. A design with a clearable flag, or one that fires while disabled, would then show a reset when none is expected. Finally, it counts pulse lengths and asserts `rst` in the middle of a pulse.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int CNT_W = 7;
    localparam int REG_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_RESET = '1;
    localparam logic [CNT_W-1:0] CNT_EDGE  = 7'h40;

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt;
    } wdg_reg_t;

    function automatic logic write_fires(input logic en_now, input logic [REG_W-1:0] d);
        return (en_now | d[REG_W-1]) & ~d[CNT_W-1];
    endfunction

    function automatic logic step_fires(input logic [CNT_W-1:0] c);
        return c == CNT_EDGE;
    endfunction
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int PRESCALE = 49152
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] div_q;

    assign tick = (div_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr || tick) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
    end

    a_r3_clear_on_write: assert property (@(posedge clk) disable iff (rst)
        clr |=> (div_q == '0));
    a_r4_never_past_last: assert property (@(posedge clk) disable iff (rst)
        div_q <= LAST);
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             tick,
    output wdg_reg_t         reg_q,
    output logic             fire
);
    wdg_reg_t reg_d;

    always_comb begin
        reg_d = reg_q;
        fire  = 1'b0;
        if (wr_en) begin
            reg_d.en  = reg_q.en | wr_data[REG_W-1];
            reg_d.cnt = wr_data[CNT_W-1:0];
            fire      = write_fires(reg_q.en, wr_data);
        end else if (tick) begin
            reg_d.cnt = reg_q.cnt - 1'b1;
            fire      = reg_q.en & step_fires(reg_q.cnt);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q.en  <= 1'b0;
            reg_q.cnt <= CNT_RESET;
        end else begin
            reg_q <= reg_d;
        end
    end

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        reg_q.en |=> reg_q.en);
    a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en) |=> (reg_q.cnt == $past(reg_q.cnt) - 1'b1));
    a_r9_quiet_disabled: assert property (@(posedge clk) disable iff (rst)
        (!reg_q.en && !(wr_en && wr_data[REG_W-1])) |-> !fire);
endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic pulse_n
);
    localparam int LW = $clog2(PULSE_LEN + 1);
    localparam logic [LW-1:0] LEN = LW'(PULSE_LEN);

    logic [LW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                  left_q <= '0;
        else if (start)           left_q <= LEN;
        else if (left_q != '0)    left_q <= left_q - 1'b1;
    end

    assign pulse_n = (left_q == '0);

    a_r8_bounded: assert property (@(posedge clk) disable iff (rst)
        left_q <= LEN);
    a_r8_starts_low: assert property (@(posedge clk) disable iff (rst)
        start |=> !pulse_n);
    a_r8_releases: assert property (@(posedge clk) disable iff (rst)
        (!start && left_q == 1) |=> pulse_n);
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int PRESCALE  = 49152,
    parameter int PULSE_LEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             wdg_rst_n
);
    logic     tick;
    logic     fire;
    wdg_reg_t reg_q;

    wdg_prescaler #(.PRESCALE(PRESCALE)) u_div (
        .clk (clk),
        .rst (rst),
        .clr (wr_en),
        .tick(tick)
    );

    wdg_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .tick   (tick),
        .reg_q  (reg_q),
        .fire   (fire)
    );

    wdg_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .start  (fire),
        .pulse_n(wdg_rst_n)
    );

    assign rd_data = reg_q;

    a_r7_bad_write_fires: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (rd_data[REG_W-1] || wr_data[REG_W-1]) && !wr_data[CNT_W-1]) |=> !wdg_rst_n);
    a_r6_edge_fires: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && tick && rd_data == 8'hC0) |=> (!wdg_rst_n && rd_data == 8'hBF));
    a_r3_write_loads: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data[CNT_W-1:0] == $past(wr_data[CNT_W-1:0])));
    a_r1_reset_value: assert property (@(posedge clk)
        rst |=> (rd_data == 8'h7F && wdg_rst_n));
endmodule

// File: tb/wdg_timer_tb.sv
module wdg_timer_tb;
    localparam int PS  = 32;
    localparam int PL  = 4;
    localparam int NV  = 8;

    typedef struct packed {
        logic [7:0] data;
        logic [7:0] ticks;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{8'hC0, 8'd0}, '{8'hC3, 8'd0}, '{8'hFF, 8'd0}, '{8'h80, 8'd0},
        '{8'hBF, 8'd0}, '{8'h45, 8'd8}, '{8'h05, 8'd10}, '{8'h3F, 8'd2}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       wdg_rst_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdg_timer #(.PRESCALE(PS), .PULSE_LEN(PL)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .wdg_rst_n(wdg_rst_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sys_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // observe cycles 0..w after a write; returns first low cycle and low count
    task automatic observe(input int w, output int first, output int lows);
        first = -1; lows = 0;
        for (int i = 0; i <= w; i++) begin
            if (i > 0) @(negedge clk);
            if (!wdg_rst_n) begin
                lows++;
                if (first < 0) first = i;
            end
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int first, lows, w, exp_first, nsteps;
        logic [7:0] d;
        logic [6:0] exp_cnt;

        sys_reset();
        // R1: reset state
        chk(rd_data == 8'h7F, "R1 reset read", rd_data, 8'h7F);
        chk(wdg_rst_n == 1'b1, "R1 reset output", wdg_rst_n, 1);

        // table walk: R2 R4 R6 R7 R8 R9
        for (int k = 0; k < NV; k++) begin
            sys_reset();
            d = VECS[k].data;
            if (d[7] && !d[6])      begin exp_first = 0; w = 8; end
            else if (d[7])          begin exp_first = (int'(d[6:0]) - 63) * PS; w = exp_first + 8; end
            else                    begin exp_first = -1; w = int'(VECS[k].ticks) * PS + 3; end
            do_write(d);
            observe(w, first, lows);
            nsteps = w / PS;
            exp_cnt = d[6:0] - 7'(nsteps);
            chk(first == exp_first, d[7] ? (d[6] ? "R6 fire cycle" : "R7 fire cycle") : "R9 no fire",
                first, exp_first);
            chk(lows == ((exp_first >= 0) ? PL : 0), "R8 pulse length", lows,
                (exp_first >= 0) ? PL : 0);
            chk(rd_data == {d[7], exp_cnt}, "R2 R4 readback", rd_data, {d[7], exp_cnt});
        end

        // R3: refresh on the edge where a step would fall; divider restarts
        sys_reset();
        do_write(8'hC1);
        for (int i = 0; i < PS - 2; i++) @(negedge clk);
        chk(rd_data == 8'hC1, "R3 no early step", rd_data, 8'hC1);
        do_write(8'hC0);
        observe(PS + 6, first, lows);
        chk(first == PS, "R3 step after full period", first, PS);

        // R10: periodic refresh prevents reset
        sys_reset();
        do_write(8'hC1);
        lows = 0;
        for (int r = 0; r < 20; r++) begin
            for (int i = 0; i < PS + PS / 2; i++) begin
                @(negedge clk);
                if (!wdg_rst_n) lows++;
            end
            do_write(8'hC1);
        end
        chk(lows == 0, "R10 refresh keeps alive", lows, 0);

        // R5: bit-7-clear write does not clear flag
        do_write(8'h50);
        chk(rd_data == 8'hD0, "R5 flag sticky", rd_data, 8'hD0);
        observe(4, first, lows);
        chk(lows == 0, "R5 no fire on bit6 set", lows, 0);
        do_write(8'h00);
        chk(!wdg_rst_n, "R7 fire with sticky flag", wdg_rst_n, 0);

        // R1: reset in mid-pulse
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(wdg_rst_n == 1'b1, "R1 reset releases pulse", wdg_rst_n, 1);
        chk(rd_data == 8'h7F, "R1 reset clears flag", rd_data, 8'h7F);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule